// File: doc/BRIEF.md
# Programmable almost-full/empty flag unit

This unit produces the two threshold flags of a dual-clock FIFO: an active-low almost-empty flag and an active-low almost-full flag. It watches the occupancy count as seen in each clock domain. It compares that count against two offset registers: one for the empty side and one for the full side. Two-flop synchronizers carry state between the write and read clock domains.

While master reset is high, the unit samples a timing-mode pin and a 3-bit preset index. The index is formed from the load pin and two select bits. The mode pin chooses between two timing schemes:
- **Split timing:** each flag is raised by one clock and dropped by the other.
- **Single-domain timing:** each flag is recomputed on one clock only.

The preset index picks one of eight starting offsets.

After reset, driving the load pin low turns the write and read strobes into accesses to the offset registers. While load is low, the strobes to the FIFO memory are gated off.

Top module: `pflag_unit`

## Requirements
- R1: While `mrst` is high, `pae_n` reads 0 (active) and `paf_n` reads 1 (inactive) once each clock has ticked during reset.
- R2: At reset both offsets load the preset `min(2^(idx+2)-1, DEPTH-1)`, where `idx = {ld_n, sel[1], sel[0]}`. Index 0 gives 3 and index 5 gives 127.
- R3: In single-domain mode (`mode_in` = 1 at reset), `pae_n` is updated only on a rising `rclk`. It equals the inverse of (`rd_count` <= empty offset) as sampled at that edge; `wclk` edges leave it unchanged.
- R4: In single-domain mode, `paf_n` is updated only on a rising `wclk`. It equals the inverse of (`DEPTH - wr_count` <= full offset) as sampled at that edge; `rclk` edges leave it unchanged.
- R5: In split mode (`mode_in` = 0 at reset), `pae_n` is driven low only by `rclk` edges, while `rd_count` <= empty offset. It is released high only by `wclk` edges, while `wr_count` > empty offset. Within three cycles of the acting clock, the flag reflects a held condition.
- R6: In split mode, `paf_n` is driven low only by `wclk` edges, while `DEPTH - wr_count` <= full offset. It is released high only by `rclk` edges, while `DEPTH - rd_count` > full offset.
- R7: While `ld_n` is low, each `wr_en` cycle on `wclk` stores `wdata`:
  - into the empty offset on the first cycle, the full offset on the second, then alternating;
  - the order restarts at the empty offset after `ld_n` has been high on a `wclk` edge.
  - With `ld_n` high, the offsets never change.
- R8: While `ld_n` is low, each `rd_en` cycle on `rclk` places an offset on `off_rdata` after that edge:
  - the empty offset first, then the full offset, alternating;
  - the order restarts after `ld_n` has been high on an `rclk` edge.
  - Otherwise `off_rdata` holds its value.
- R9: `fifo_wen` equals `wr_en & ld_n` and `fifo_ren` equals `rd_en & ld_n`, with no clock delay.
- R10: The compare is inclusive. An occupancy equal to the empty offset makes almost-empty active, and one above it does not. Free space equal to the full offset makes almost-full active, and one above it does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| mrst | input | 1 | Master reset, active high, sampled by both clocks |
| ld_n | input | 1 | Low selects offset-register access; sampled into preset index at reset |
| sel | input | 2 | Preset select bits, sampled at reset |
| mode_in | input | 1 | Timing mode at reset: 0 split, 1 single-domain |
| wr_en | input | 1 | Write strobe (FIFO write or offset write) |
| rd_en | input | 1 | Read strobe (FIFO read or offset read) |
| wdata | input | $clog2(DEPTH) | Offset value for parallel writes |
| wr_count | input | $clog2(DEPTH+1) | Occupancy as seen in the write domain |
| rd_count | input | $clog2(DEPTH+1) | Occupancy as seen in the read domain |
| fifo_wen | output | 1 | Gated write strobe to FIFO memory |
| fifo_ren | output | 1 | Gated read strobe to FIFO memory |
| off_rdata | output | $clog2(DEPTH) | Offset read-back data |
| pae_n | output | 1 | Almost-empty flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |

## Verification
In single-domain mode, the occupancy inputs are swept in two ways:
- linear ramps across each threshold, which expose an off-by-one or a strict-versus-inclusive compare;
- scattered values over the whole count range, which expose wrong arithmetic on free space.

In both sweeps each flag is checked on every edge of its clock. With one clock halted, the bench moves the other domain's occupancy across its threshold. This shows which clock is allowed to move each flag, which separates the two timing modes. Offset programming is exercised with three writes and three reads, so that the alternation order, its restart on a rising load pin and the preset selected at reset are all visible on the read-back port.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

    typedef enum logic {
        TIMING_SPLIT  = 1'b0,
        TIMING_SINGLE = 1'b1
    } flag_timing_e;

    // Preset threshold chosen at reset: 2^(idx+2)-1, clipped to the depth.
    function automatic int unsigned preset_offset(input logic [2:0] idx,
                                                  input int unsigned depth);
        int unsigned raw;
        raw = (32'd1 << (int'(idx) + 2)) - 32'd1;
        if (raw > depth - 1) raw = depth - 1;
        return raw;
    endfunction

endpackage

// File: rtl/pflag_sync2.sv
module pflag_sync2 #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        if (rst) begin
            st_d.s1 = RST_VAL;
            st_d.s2 = RST_VAL;
        end else begin
            st_d.s1 = d;
            st_d.s2 = st_q.s1;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign q = st_q.s2;
endmodule

// File: rtl/pflag_cell.sv
// One threshold flag. The "set" domain may raise it, the "clear" domain may
// drop it (split mode); in single-domain mode only the set domain updates it.
module pflag_cell #(
    parameter bit RST_ACTIVE = 1'b0
) (
    input  logic set_clk,
    input  logic set_rst,
    input  logic set_single,
    input  logic set_cond,
    input  logic clr_clk,
    input  logic clr_rst,
    input  logic clr_single,
    input  logic clr_cond,
    output logic active
);
    typedef struct packed {
        logic tog;
        logic lvl;
    } set_t;

    set_t sq_d, sq_q;
    logic tc_d, tc_q;
    logic tc_seen;
    logic ts_seen;

    pflag_sync2 #(.RST_VAL(1'b0)) u_tc_sync (
        .clk (set_clk),
        .rst (set_rst),
        .d   (tc_q),
        .q   (tc_seen)
    );

    pflag_sync2 #(.RST_VAL(RST_ACTIVE)) u_ts_sync (
        .clk (clr_clk),
        .rst (clr_rst),
        .d   (sq_q.tog),
        .q   (ts_seen)
    );

    // Set-domain next state
    always_comb begin
        sq_d = sq_q;
        if (set_rst) begin
            sq_d.tog = RST_ACTIVE;
            sq_d.lvl = RST_ACTIVE;
        end else if (set_single) begin
            sq_d.lvl = set_cond;
        end else if (set_cond && (sq_q.tog == tc_seen)) begin
            sq_d.tog = ~sq_q.tog;
        end
    end

    always_ff @(posedge set_clk) sq_q <= sq_d;

    // Clear-domain next state
    always_comb begin
        tc_d = tc_q;
        if (clr_rst) begin
            tc_d = 1'b0;
        end else if (!clr_single && clr_cond && (tc_q != ts_seen)) begin
            tc_d = ~tc_q;
        end
    end

    always_ff @(posedge clr_clk) tc_q <= tc_d;

    assign active = set_single ? sq_q.lvl : (sq_q.tog ^ tc_q);

    // R5 / R6: the set side only ever raises an inactive flag
    assert_set_when_idle_R5 : assert property (
        @(posedge set_clk) disable iff (set_rst || clr_rst)
        (!set_single && (sq_d.tog != sq_q.tog)) |-> !(sq_q.tog ^ tc_q)
    ) else $error("set side toggled while flag already active");

    // R6 / R5: the clear side only ever drops an active flag
    assert_clear_when_active_R6 : assert property (
        @(posedge clr_clk) disable iff (set_rst || clr_rst)
        (!clr_single && (tc_d != tc_q)) |-> (sq_q.tog ^ tc_q)
    ) else $error("clear side toggled while flag inactive");

endmodule

// File: rtl/pflag_offsets.sv
module pflag_offsets
    import pflag_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int OFF_W = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             wrst,
    input  logic             ld_n,
    input  logic [2:0]       preset_idx,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wdata,
    input  logic             rclk,
    input  logic             rrst,
    input  logic             rd_en,
    output logic [OFF_W-1:0] off_e,
    output logic [OFF_W-1:0] off_f,
    output logic [OFF_W-1:0] rdata
);
    typedef struct packed {
        logic [OFF_W-1:0] e;
        logic [OFF_W-1:0] f;
        logic             nxt_full;
    } wside_t;

    typedef struct packed {
        logic [OFF_W-1:0] data;
        logic             nxt_full;
    } rside_t;

    wside_t w_d, w_q;
    rside_t r_d, r_q;

    always_comb begin
        w_d = w_q;
        if (wrst) begin
            w_d.e        = OFF_W'(preset_offset(preset_idx, DEPTH));
            w_d.f        = OFF_W'(preset_offset(preset_idx, DEPTH));
            w_d.nxt_full = 1'b0;
        end else if (ld_n) begin
            w_d.nxt_full = 1'b0;
        end else if (wr_en) begin
            if (w_q.nxt_full) w_d.f = wdata;
            else              w_d.e = wdata;
            w_d.nxt_full = ~w_q.nxt_full;
        end
    end

    always_ff @(posedge wclk) w_q <= w_d;

    always_comb begin
        r_d = r_q;
        if (rrst) begin
            r_d.data     = '0;
            r_d.nxt_full = 1'b0;
        end else if (ld_n) begin
            r_d.nxt_full = 1'b0;
        end else if (rd_en) begin
            r_d.data     = r_q.nxt_full ? w_q.f : w_q.e;
            r_d.nxt_full = ~r_q.nxt_full;
        end
    end

    always_ff @(posedge rclk) r_q <= r_d;

    assign off_e = w_q.e;
    assign off_f = w_q.f;
    assign rdata = r_q.data;

    assert_offsets_hold_R7 : assert property (
        @(posedge wclk) disable iff (wrst)
        ld_n |=> ($stable(off_e) && $stable(off_f))
    ) else $error("offset changed with load high");

    assert_readback_hold_R8 : assert property (
        @(posedge rclk) disable iff (rrst)
        !(rd_en && !ld_n) |=> $stable(rdata)
    ) else $error("read-back data changed without a read");

endmodule

// File: rtl/pflag_unit.sv
module pflag_unit
    import pflag_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                       wclk,
    input  logic                       rclk,
    input  logic                       mrst,
    input  logic                       ld_n,
    input  logic [1:0]                 sel,
    input  logic                       mode_in,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [$clog2(DEPTH)-1:0]   wdata,
    input  logic [$clog2(DEPTH+1)-1:0] wr_count,
    input  logic [$clog2(DEPTH+1)-1:0] rd_count,
    output logic                       fifo_wen,
    output logic                       fifo_ren,
    output logic [$clog2(DEPTH)-1:0]   off_rdata,
    output logic                       pae_n,
    output logic                       paf_n
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int OFF_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    flag_timing_e mode_w_d, mode_w_q;
    flag_timing_e mode_r_d, mode_r_q;

    logic [OFF_W-1:0] off_e, off_f;
    logic [CNT_W-1:0] off_e_x, off_f_x;
    logic [CNT_W-1:0] free_w, free_r;
    logic             ae_set, ae_clr, af_set, af_clr;
    logic             ae_active, af_active;
    logic             single_w, single_r;

    // Mode capture, one copy per domain
    always_comb begin
        mode_w_d = mrst ? flag_timing_e'(mode_in) : mode_w_q;
        mode_r_d = mrst ? flag_timing_e'(mode_in) : mode_r_q;
    end

    always_ff @(posedge wclk) mode_w_q <= mode_w_d;
    always_ff @(posedge rclk) mode_r_q <= mode_r_d;

    assign single_w = (mode_w_q == TIMING_SINGLE);
    assign single_r = (mode_r_q == TIMING_SINGLE);

    pflag_offsets #(.DEPTH(DEPTH), .OFF_W(OFF_W)) u_offsets (
        .wclk       (wclk),
        .wrst       (mrst),
        .ld_n       (ld_n),
        .preset_idx ({ld_n, sel}),
        .wr_en      (wr_en),
        .wdata      (wdata),
        .rclk       (rclk),
        .rrst       (mrst),
        .rd_en      (rd_en),
        .off_e      (off_e),
        .off_f      (off_f),
        .rdata      (off_rdata)
    );

    // Threshold compares (inclusive)
    always_comb begin
        off_e_x = CNT_W'(off_e);
        off_f_x = CNT_W'(off_f);
        free_w  = DEPTH_C - wr_count;
        free_r  = DEPTH_C - rd_count;
        ae_set  = (rd_count <= off_e_x);
        ae_clr  = (wr_count >  off_e_x);
        af_set  = (free_w   <= off_f_x);
        af_clr  = (free_r   >  off_f_x);
    end

    pflag_cell #(.RST_ACTIVE(1'b1)) u_empty_flag (
        .set_clk    (rclk),
        .set_rst    (mrst),
        .set_single (single_r),
        .set_cond   (ae_set),
        .clr_clk    (wclk),
        .clr_rst    (mrst),
        .clr_single (single_w),
        .clr_cond   (ae_clr),
        .active     (ae_active)
    );

    pflag_cell #(.RST_ACTIVE(1'b0)) u_full_flag (
        .set_clk    (wclk),
        .set_rst    (mrst),
        .set_single (single_w),
        .set_cond   (af_set),
        .clr_clk    (rclk),
        .clr_rst    (mrst),
        .clr_single (single_r),
        .clr_cond   (af_clr),
        .active     (af_active)
    );

    assign pae_n    = ~ae_active;
    assign paf_n    = ~af_active;
    assign fifo_wen = wr_en & ld_n;
    assign fifo_ren = rd_en & ld_n;

    assert_single_empty_R3 : assert property (
        @(posedge rclk) disable iff (mrst)
        single_r |=> (pae_n == !$past(ae_set))
    ) else $error("almost-empty did not follow read-domain compare");

    assert_single_full_R4 : assert property (
        @(posedge wclk) disable iff (mrst)
        single_w |=> (paf_n == !$past(af_set))
    ) else $error("almost-full did not follow write-domain compare");

endmodule

// File: tb/pflag_unit_bench.sv
`timescale 1ns/1ps
module pflag_unit_bench;
    localparam int DEPTH = 1024;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int OFF_W = $clog2(DEPTH);

    logic wclk = 1'b0, rclk = 1'b0;
    logic wclk_en = 1'b1, rclk_en = 1'b1;
    logic mrst = 1'b1, ld_n = 1'b1, mode_in = 1'b1;
    logic [1:0] sel = 2'b01;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [OFF_W-1:0] wdata = '0;
    logic [CNT_W-1:0] wr_count = '0, rd_count = '0;
    logic fifo_wen, fifo_ren, pae_n, paf_n;
    logic [OFF_W-1:0] off_rdata;

    int n_tests = 0, n_fail = 0;
    int m_off_e = 0, m_off_f = 0;
    bit chk_on = 1'b0;
    bit finished = 1'b0;

    pflag_unit #(.DEPTH(DEPTH)) u_pflag_unit (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .ld_n(ld_n), .sel(sel),
        .mode_in(mode_in), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .wr_count(wr_count), .rd_count(rd_count), .fifo_wen(fifo_wen),
        .fifo_ren(fifo_ren), .off_rdata(off_rdata), .pae_n(pae_n), .paf_n(paf_n)
    );

    // 200 MHz write clock, slower read clock; both can be halted
    always begin #2.5; if (wclk_en) wclk = ~wclk; end
    always begin #3.5; if (rclk_en) rclk = ~rclk; end

    task automatic check(input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_w(input int n);
        wclk_en = 1'b1;
        repeat (n) @(posedge wclk);
        #1 wclk_en = 1'b0;
    endtask

    task automatic run_r(input int n);
        rclk_en = 1'b1;
        repeat (n) @(posedge rclk);
        #1 rclk_en = 1'b0;
    endtask

    task automatic wr_off(input int v);
        @(negedge wclk);
        wr_en = 1'b1;
        wdata = OFF_W'(v);
        #0.5 check("R9 write strobe gated while loading", int'(fifo_wen), 0);
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic rd_off(output int v);
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
        v = int'(off_rdata);
    endtask

    // Per-clock reference model for single-domain mode (R3, R4)
    int exp_ae, exp_af;
    always @(posedge rclk) if (chk_on) begin
        exp_ae = (int'(rd_count) <= m_off_e) ? 0 : 1;
        #1 check("R3 per-cycle almost-empty", int'(pae_n), exp_ae);
    end
    always @(posedge wclk) if (chk_on) begin
        exp_af = ((DEPTH - int'(wr_count)) <= m_off_f) ? 0 : 1;
        #1 check("R4 per-cycle almost-full", int'(paf_n), exp_af);
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        // ---------------- single-domain phase ----------------
        repeat (6) @(posedge rclk);
        #1;
        check("R1 pae_n during reset", int'(pae_n), 0);
        check("R1 paf_n during reset", int'(paf_n), 1);
        @(negedge wclk) mrst = 1'b0;
        repeat (3) @(posedge rclk);

        @(negedge rclk) ld_n = 1'b0;
        rd_off(v); check("R2 preset idx5 empty", v, 127);
        rd_off(v); check("R2 preset idx5 full", v, 127);

        wr_off(50);
        wr_off(900);
        wr_off(20);
        @(negedge rclk) ld_n = 1'b1;
        repeat (3) @(posedge wclk);
        @(negedge wclk) begin wr_en = 1'b1; rd_en = 1'b1; end
        #0.5;
        check("R9 write strobe passes with load high", int'(fifo_wen), 1);
        check("R9 read strobe passes with load high", int'(fifo_ren), 1);
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (3) @(posedge rclk);

        @(negedge rclk) ld_n = 1'b0;
        repeat (2) @(posedge rclk);
        rd_off(v); check("R8 first read is empty offset (R7 third write)", v, 20);
        rd_off(v); check("R8 second read is full offset (R7)", v, 900);
        rd_off(v); check("R8 third read wraps to empty", v, 20);
        @(negedge rclk) ld_n = 1'b1;
        repeat (3) @(posedge wclk);
        m_off_e = 20;
        m_off_f = 900;

        @(negedge rclk) chk_on = 1'b1;
        fork
            for (int i = 0; i < 80; i++) begin
                @(negedge rclk);
                rd_count = (i < 40) ? CNT_W'(i) : CNT_W'((i * 173 + 11) % (DEPTH + 1));
            end
            for (int i = 0; i < 80; i++) begin
                @(negedge wclk);
                wr_count = (i < 40) ? CNT_W'(104 + i) : CNT_W'((i * 311 + 7) % (DEPTH + 1));
            end
        join
        @(negedge rclk) chk_on = 1'b0;

        @(negedge rclk) rd_count = CNT_W'(20);
        @(negedge rclk) check("R10 occupancy equal to empty offset", int'(pae_n), 0);
        rd_count = CNT_W'(21);
        @(negedge rclk) check("R10 occupancy one above empty offset", int'(pae_n), 1);
        @(negedge wclk) wr_count = CNT_W'(124);
        @(negedge wclk) check("R10 free space equal to full offset", int'(paf_n), 0);
        wr_count = CNT_W'(123);
        @(negedge wclk) check("R10 free space one above full offset", int'(paf_n), 1);

        wclk_en = 1'b0;
        rclk_en = 1'b0;
        rd_count = CNT_W'(500);
        run_r(2);
        check("R3 high occupancy inactive", int'(pae_n), 1);
        rd_count = CNT_W'(0);
        run_w(6);
        check("R3 write clock leaves almost-empty alone", int'(pae_n), 1);
        run_r(1);
        check("R3 read clock updates almost-empty", int'(pae_n), 0);
        wr_count = CNT_W'(0);
        run_w(2);
        check("R4 empty FIFO not almost-full", int'(paf_n), 1);
        wr_count = CNT_W'(1000);
        run_r(6);
        check("R4 read clock leaves almost-full alone", int'(paf_n), 1);
        run_w(1);
        check("R4 write clock updates almost-full", int'(paf_n), 0);

        // ---------------- split-timing phase ----------------
        wclk_en = 1'b1;
        rclk_en = 1'b1;
        mrst = 1'b1;
        mode_in = 1'b0;
        ld_n = 1'b0;
        sel = 2'b00;
        rd_count = '0;
        wr_count = '0;
        repeat (6) @(posedge rclk);
        #1;
        check("R1 pae_n during second reset", int'(pae_n), 0);
        check("R1 paf_n during second reset", int'(paf_n), 1);
        @(negedge wclk) mrst = 1'b0;
        repeat (3) @(posedge rclk);
        rd_off(v); check("R2 preset idx0 empty", v, 3);
        rd_off(v); check("R2 preset idx0 full", v, 3);
        @(negedge rclk) ld_n = 1'b1;
        repeat (4) @(posedge wclk);
        repeat (2) @(posedge rclk);

        wclk_en = 1'b0;
        rclk_en = 1'b0;
        rd_count = CNT_W'(10);
        wr_count = CNT_W'(10);
        run_w(6);
        check("R5 write clock releases almost-empty", int'(pae_n), 1);
        rd_count = CNT_W'(2);
        run_r(6);
        check("R5 read clock asserts almost-empty", int'(pae_n), 0);
        rd_count = CNT_W'(10);
        run_r(6);
        check("R5 read clock cannot release almost-empty", int'(pae_n), 0);
        run_w(6);
        check("R5 write clock releases again", int'(pae_n), 1);
        wr_count = CNT_W'(2);
        rd_count = CNT_W'(2);
        run_w(6);
        check("R5 write clock cannot assert almost-empty", int'(pae_n), 1);
        run_r(6);
        check("R5 read clock asserts after write-only run", int'(pae_n), 0);

        rd_count = CNT_W'(1022);
        wr_count = CNT_W'(1022);
        run_r(6);
        check("R6 read clock cannot assert almost-full", int'(paf_n), 1);
        run_w(6);
        check("R6 write clock asserts almost-full", int'(paf_n), 0);
        wr_count = CNT_W'(100);
        run_w(6);
        check("R6 write clock cannot release almost-full", int'(paf_n), 0);
        rd_count = CNT_W'(100);
        run_r(6);
        check("R6 read clock releases almost-full", int'(paf_n), 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule